// File: doc/BRIEF.md
# Watchdog Timer with Guarded Feed

This block is a watchdog for a simple single-cycle peripheral bus. A down-counter is reloaded from a programmable reload constant, and only a two-write key sequence on the feed register can trigger that reload. Once software has armed the watchdog, the counter steps down on ticks from one of three count sources. It raises either a reset request or an interrupt request when the count runs out. The same request is raised when the key sequence is interrupted by a stray access to any watchdog register.

The count source is picked by a two-bit select field. The choices are an external RC-oscillator tick, every cycle of the bus clock, an external RTC tick, or no source at all. The live count is read back through a value register that lags the counter by a fixed number of cycles, set by a parameter. Addresses that decode to no watchdog register are ordinary bus traffic and never touch the watchdog.

Top module: `wdog_feed_guard`

Register offsets (byte addresses): control 0x00, feed 0x04, reload 0x08, source select 0x0C, value 0x10. An access is any cycle with `bus_sel_i` high. Reads return data in the same cycle.

## Requirements
- R1: After reset, the value register reads 0x000000FF, the reload register reads 0x000000FF, the select and control registers read 0, and both request outputs are low.
- R2: A write of 0xAA to the feed register, followed by a write of 0x55 to the feed register, loads the counter from the reload register. Only bits 7:0 of a feed write are looked at.
- R3: A first feed byte other than 0xAA leaves the sequencer idle, so a following 0x55 reloads nothing. While disabled, a second byte other than 0x55 returns the sequencer to idle without a reload.
- R4: While enabled, with 0xAA accepted, any read or write of a watchdog register other than writing 0x55 to the feed register breaks the sequence. The request output rises on the second clock edge after the breaking access. Accesses to other addresses do not break the sequence.
- R5: While enabled, the counter drops by one on each clock edge where the selected source ticks. Select code 00 uses `tick_rc_i`, 01 uses every clock, 10 uses `tick_rtc_i`, and 11 never advances. While disabled, the counter does not move.
- R6: When an enabled counter reaches zero, a request rises on the next clock edge. Control bit 1 picks the kind: 1 gives the reset request and 0 gives the interrupt request. The request holds until system reset, even if feeds follow.
- R7: Control bit 0 is the enable and can only be set; writing 0 does not clear it. Control bit 1 is frozen once enable is set.
- R8: The value register shows the count as it stood SNAP_LAG clock edges earlier.
- R9: If a completed feed and a selected tick land on the same edge, the reload wins, and the counter holds the reload constant.
- R10: The select register keeps only bits 1:0 of a write, and its bits 31:2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| bus_sel_i | input | 1 | Access strobe, one access per cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, same cycle |
| tick_rc_i | input | 1 | RC-oscillator count tick |
| tick_rtc_i | input | 1 | RTC count tick |
| wd_rst_o | output | 1 | Sticky reset request |
| wd_irq_o | output | 1 | Sticky interrupt request |

## Verification
Two functions can fall on one edge: the second feed byte reloading the counter, and a selected tick decrementing it. The bench brings the count to one on the RC source, then holds `tick_rc_i` high during the 0x55 write. The collision is judged by reading back the reload constant after the snapshot lag and by seeing the interrupt stay low. A second collision, between a breaking access and the two-edge request delay, is judged edge by edge.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_FEED   = 8'h04;
    localparam logic [7:0] OFS_RELOAD = 8'h08;
    localparam logic [7:0] OFS_SEL    = 8'h0C;
    localparam logic [7:0] OFS_VALUE  = 8'h10;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    typedef enum logic [1:0] {
        SRC_RC   = 2'b00,
        SRC_BUS  = 2'b01,
        SRC_RTC  = 2'b10,
        SRC_NONE = 2'b11
    } src_e;

    typedef enum logic {
        FEED_IDLE  = 1'b0,
        FEED_ARMED = 1'b1
    } feed_st_e;
endpackage

// File: rtl/wdg_feed_fsm.sv
`timescale 1ns/1ps
module wdg_feed_fsm (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       reg_acc_i,
    input  logic       feed_wr_i,
    input  logic [7:0] feed_byte_i,
    input  logic       enabled_i,
    output logic       load_o,
    output logic       breach_o,
    output logic       armed_o
);
    import wdg_pkg::*;

    typedef struct packed {
        feed_st_e state;
        logic     breach;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    load_c;

    always_comb begin
        st_d        = st_q;
        st_d.breach = 1'b0;
        load_c      = 1'b0;
        unique case (st_q.state)
            FEED_IDLE: begin
                if (feed_wr_i && feed_byte_i == KEY_FIRST) begin
                    st_d.state = FEED_ARMED;
                end
            end
            FEED_ARMED: begin
                if (reg_acc_i) begin
                    st_d.state = FEED_IDLE;
                    if (feed_wr_i && feed_byte_i == KEY_SECOND) begin
                        load_c = 1'b1;
                    end else begin
                        st_d.breach = enabled_i;
                    end
                end
            end
            default: st_d.state = FEED_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{state: FEED_IDLE, breach: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o   = load_c;
    assign breach_o = st_q.breach;
    assign armed_o  = (st_q.state == FEED_ARMED);
endmodule

// File: rtl/wdg_countdown.sv
`timescale 1ns/1ps
module wdg_countdown #(
    parameter int unsigned     W    = 32,
    parameter logic [W-1:0]    INIT = 'hFF
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_rc_i,
    input  logic         tick_rtc_i,
    input  logic [1:0]   sel_i,
    input  logic         en_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic         zero_o
);
    localparam int unsigned NSRC = 4;

    typedef struct packed {
        logic [W-1:0] count;
    } cd_st_t;

    cd_st_t          st_d, st_q;
    logic [NSRC-1:0] src_tick;
    logic            step;

    // index matches the select code: RC, bus clock, RTC, none
    assign src_tick = {1'b0, tick_rtc_i, 1'b1, tick_rc_i};
    assign step     = src_tick[sel_i];

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (en_i && step && st_q.count != '0) begin
            st_d.count = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.count <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign zero_o  = (st_q.count == '0);
endmodule

// File: rtl/wdg_snap_pipe.sv
`timescale 1ns/1ps
module wdg_snap_pipe #(
    parameter int unsigned  W     = 32,
    parameter int unsigned  DEPTH = 3,
    parameter logic [W-1:0] INIT  = 'hFF
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stg_d[g] = din_i;
        end else begin : g_tail
            assign stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stg_q[g] <= INIT;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign dout_o = stg_q[DEPTH-1];
endmodule

// File: rtl/wdog_feed_guard.sv
`timescale 1ns/1ps
module wdog_feed_guard #(
    parameter int unsigned       ADDR_W     = 8,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       SNAP_LAG   = 3,
    parameter logic [DATA_W-1:0] INIT_COUNT = 'hFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tick_rc_i,
    input  logic              tick_rtc_i,
    output logic              wd_rst_o,
    output logic              wd_irq_o
);
    import wdg_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_FEED   = ADDR_W'(OFS_FEED);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);

    typedef struct packed {
        logic              en;
        logic              mode;
        logic [DATA_W-1:0] reload;
        logic [1:0]        sel;
        logic              fired;
        logic              kind;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              hit_ctrl, hit_feed, hit_reload, hit_sel, hit_value, reg_acc;
    logic              feed_load, feed_breach, feed_armed;
    logic [DATA_W-1:0] count, snap;
    logic              cnt_zero, trip;

    assign hit_ctrl   = bus_sel_i && bus_addr_i == A_CTRL;
    assign hit_feed   = bus_sel_i && bus_addr_i == A_FEED;
    assign hit_reload = bus_sel_i && bus_addr_i == A_RELOAD;
    assign hit_sel    = bus_sel_i && bus_addr_i == A_SEL;
    assign hit_value  = bus_sel_i && bus_addr_i == A_VALUE;
    assign reg_acc    = hit_ctrl | hit_feed | hit_reload | hit_sel | hit_value;

    wdg_feed_fsm u_feed (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reg_acc_i   (reg_acc),
        .feed_wr_i   (hit_feed && bus_wr_i),
        .feed_byte_i (bus_wdata_i[7:0]),
        .enabled_i   (st_q.en),
        .load_o      (feed_load),
        .breach_o    (feed_breach),
        .armed_o     (feed_armed)
    );

    wdg_countdown #(
        .W    (DATA_W),
        .INIT (INIT_COUNT)
    ) u_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_rc_i  (tick_rc_i),
        .tick_rtc_i (tick_rtc_i),
        .sel_i      (st_q.sel),
        .en_i       (st_q.en),
        .load_i     (feed_load),
        .load_val_i (st_q.reload),
        .count_o    (count),
        .zero_o     (cnt_zero)
    );

    wdg_snap_pipe #(
        .W     (DATA_W),
        .DEPTH (SNAP_LAG),
        .INIT  (INIT_COUNT)
    ) u_snap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (count),
        .dout_o (snap)
    );

    assign trip = feed_breach | (st_q.en & cnt_zero);

    always_comb begin
        st_d = st_q;
        if (hit_ctrl && bus_wr_i) begin
            st_d.en = st_q.en | bus_wdata_i[0];
            if (!st_q.en) begin
                st_d.mode = bus_wdata_i[1];
            end
        end
        if (hit_reload && bus_wr_i) begin
            st_d.reload = bus_wdata_i;
        end
        if (hit_sel && bus_wr_i) begin
            st_d.sel = bus_wdata_i[1:0];
        end
        if (trip && !st_q.fired) begin
            st_d.fired = 1'b1;
            st_d.kind  = st_q.mode;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{en: 1'b0, mode: 1'b0, reload: INIT_COUNT,
                      sel: SRC_RC, fired: 1'b0, kind: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (hit_ctrl)   bus_rdata_o[1:0] = {st_q.mode, st_q.en};
        if (hit_reload) bus_rdata_o      = st_q.reload;
        if (hit_sel)    bus_rdata_o[1:0] = st_q.sel;
        if (hit_value)  bus_rdata_o      = snap;
    end

    assign wd_rst_o = st_q.fired &  st_q.kind;
    assign wd_irq_o = st_q.fired & ~st_q.kind;
endmodule

// File: rtl/wdog_feed_guard_chk.sv
`timescale 1ns/1ps
module wdog_feed_guard_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [7:0]        feed_byte,
    input logic              wd_rst_o,
    input logic              wd_irq_o,
    input logic              en_q,
    input logic [1:0]        sel_q,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] reload_q,
    input logic              load,
    input logic              armed
);
    import wdg_pkg::*;

    logic wd_hit, good_second;
    assign wd_hit = bus_sel_i && (bus_addr_i == ADDR_W'(OFS_CTRL)   ||
                                  bus_addr_i == ADDR_W'(OFS_FEED)   ||
                                  bus_addr_i == ADDR_W'(OFS_RELOAD) ||
                                  bus_addr_i == ADDR_W'(OFS_SEL)    ||
                                  bus_addr_i == ADDR_W'(OFS_VALUE));
    assign good_second = bus_wr_i && bus_addr_i == ADDR_W'(OFS_FEED) &&
                         feed_byte == KEY_SECOND;

    p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |=> count_q == $past(reload_q));

    p_breach_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && en_q && wd_hit && !good_second) |=> ##1 (wd_rst_o || wd_irq_o));

    p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_q == 2'b11 && !load) |=> $stable(count_q));

    p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_q && !load) |=> $stable(count_q));

    p_no_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load |=> count_q <= $past(count_q));

    p_hold_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_rst_o |=> wd_rst_o);

    p_hold_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_irq_o |=> wd_irq_o);

    p_one_kind_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wd_rst_o && wd_irq_o));

    p_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q |=> en_q);
endmodule

bind wdog_feed_guard wdog_feed_guard_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_sel_i  (bus_sel_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .feed_byte  (bus_wdata_i[7:0]),
    .wd_rst_o   (wd_rst_o),
    .wd_irq_o   (wd_irq_o),
    .en_q       (st_q.en),
    .sel_q      (st_q.sel),
    .count_q    (count),
    .reload_q   (st_q.reload),
    .load       (feed_load),
    .armed      (feed_armed)
);

// File: tb/wdog_feed_guard_test.sv
`timescale 1ns/1ps
module wdog_feed_guard_test;
    localparam int LAG = 3;
    localparam logic [7:0] A_CTRL = 8'h00, A_FEED = 8'h04, A_RELOAD = 8'h08,
                           A_SEL = 8'h0C, A_VALUE = 8'h10, A_OTHER = 8'h40;

    typedef struct packed {
        logic [1:0]  sel;
        logic        rc;
        logic        rtc;
        logic [7:0]  win;
        logic [15:0] dec;
    } vec_t;

    // select code 01 also counts on the edge that writes 11 back
    localparam vec_t VECS [6] = '{
        '{sel: 2'b00, rc: 1'b1, rtc: 1'b0, win: 8'd7, dec: 16'd7},
        '{sel: 2'b00, rc: 1'b0, rtc: 1'b1, win: 8'd5, dec: 16'd0},
        '{sel: 2'b10, rc: 1'b0, rtc: 1'b1, win: 8'd9, dec: 16'd9},
        '{sel: 2'b10, rc: 1'b1, rtc: 1'b0, win: 8'd4, dec: 16'd0},
        '{sel: 2'b11, rc: 1'b1, rtc: 1'b1, win: 8'd6, dec: 16'd0},
        '{sel: 2'b01, rc: 1'b0, rtc: 1'b0, win: 8'd3, dec: 16'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tick_rc = 1'b0, tick_rtc = 1'b0;
    logic        wd_rst, wd_irq;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_feed_guard #(.ADDR_W(8), .DATA_W(32), .SNAP_LAG(LAG)) uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tick_rc_i(tick_rc), .tick_rtc_i(tick_rtc), .wd_rst_o(wd_rst), .wd_irq_o(wd_irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1 r = bus_rdata;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r;
        acc(1'b1, a, d, r);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        acc(1'b0, a, '0, r);
    endtask

    task automatic feed();
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'h55);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle_value(output logic [31:0] r);
        repeat (LAG + 1) step();
        rd(A_VALUE, r);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(A_VALUE, r);  chk("R1 value", r, 32'hFF);
        rd(A_RELOAD, r); chk("R1 reload", r, 32'hFF);
        rd(A_SEL, r);    chk("R1 select", r, 32'h0);
        rd(A_CTRL, r);   chk("R1 control", r, 32'h0);
        chk("R1 outputs", {30'd0, wd_rst, wd_irq}, 32'h0);

        // R3 broken sequences while disabled, then R2 good pair
        wr(A_RELOAD, 32'h40);
        wr(A_FEED, 32'hAA); wr(A_FEED, 32'h66); wr(A_FEED, 32'h55);
        settle_value(r); chk("R3 wrong second byte", r, 32'hFF);
        wr(A_FEED, 32'h12); wr(A_FEED, 32'h55);
        settle_value(r); chk("R3 wrong first byte", r, 32'hFF);
        chk("R3 no request when disabled", {30'd0, wd_rst, wd_irq}, 32'h0);
        feed();
        settle_value(r); chk("R2 feed reload", r, 32'h40);

        // R10 select field width
        wr(A_SEL, 32'hFFFF_FFF6);
        rd(A_SEL, r); chk("R10 select bits", r, 32'h2);

        // enable, interrupt mode; R5 vectors
        wr(A_CTRL, 32'h1);
        wr(A_RELOAD, 32'h1000);
        for (int i = 0; i < 6; i++) begin
            wr(A_SEL, 32'h3);
            feed();
            wr(A_SEL, {30'd0, VECS[i].sel});
            tick_rc = VECS[i].rc; tick_rtc = VECS[i].rtc;
            repeat (int'(VECS[i].win)) step();
            tick_rc = 1'b0; tick_rtc = 1'b0;
            wr(A_SEL, 32'h3);
            settle_value(r);
            chk($sformatf("R5 vector %0d", i), r, 32'h1000 - 32'(VECS[i].dec));
        end

        // R8 snapshot lag: count frozen at 0xFFC
        wr(A_RELOAD, 32'h2222);
        feed();
        for (int i = 0; i <= LAG; i++) begin
            rd(A_VALUE, r);
            if (i == LAG - 1) chk("R8 value still old", r, 32'hFFC);
            if (i == LAG)     chk("R8 value updated", r, 32'h2222);
        end

        // R9 feed completes on the same edge as a tick at count 1
        wr(A_RELOAD, 32'h2);
        feed();
        wr(A_SEL, 32'h0);
        tick_rc = 1'b1; step(); tick_rc = 1'b0;
        wr(A_FEED, 32'hAA);
        tick_rc = 1'b1; wr(A_FEED, 32'h55); tick_rc = 1'b0;
        settle_value(r); chk("R9 reload wins", r, 32'h2);
        chk("R9 no interrupt", {31'd0, wd_irq}, 32'h0);

        // R6 expiry in interrupt mode
        tick_rc = 1'b1; step(); step(); tick_rc = 1'b0;
        chk("R6 not yet at zero edge", {31'd0, wd_irq}, 32'h0);
        step();
        chk("R6 interrupt raised", {30'd0, wd_rst, wd_irq}, 32'h1);

        // R7 enable lock and mode freeze
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, r); chk("R7 enable stays", r, 32'h1);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, r); chk("R7 mode frozen", r, 32'h1);
        feed(); step();
        chk("R6 request held after feed", {30'd0, wd_rst, wd_irq}, 32'h1);

        // R4 broken sequence in reset mode
        do_reset();
        chk("R1 outputs after reset", {30'd0, wd_rst, wd_irq}, 32'h0);
        wr(A_CTRL, 32'h3);
        wr(A_FEED, 32'hAA);
        rd(A_OTHER, r);
        wr(A_FEED, 32'h55);
        step(); step();
        chk("R4 other address harmless", {30'd0, wd_rst, wd_irq}, 32'h0);
        wr(A_FEED, 32'hAA);
        rd(A_VALUE, r);
        chk("R4 low after first edge", {30'd0, wd_rst, wd_irq}, 32'h0);
        step();
        chk("R4 reset on second edge", {30'd0, wd_rst, wd_irq}, 32'h2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule